// File: doc/BRIEF.md
# Predicated Matrix Tile Slice Writer

This block holds a square byte-addressed matrix whose side is one vector length (128 bits by default, so 16 rows of 16 bytes). Software-visible tiles are overlaid on that storage according to an element width of 8, 16, 32, 64 or 128 bits. Narrow elements give one large tile. Each doubling of the width halves the tile side and doubles the number of tiles.

One command per clock writes a source vector into a single row or a single column of one tile. The target position comes from a 32-bit index plus a small immediate, wrapped to the tile side. A byte-granular predicate chooses which elements are written. Elements that are not selected keep their old contents.

A registered read port returns any physical row of the storage, so the result of a write can be observed.

Top module: `matrix_slice_writer`

## Requirements
- R1: A synchronous active-high reset clears every storage byte to zero, and clears `rd_data` and `cmd_err`.
- R2: Horizontal write (`cmd_vert`=0): element e of `cmd_src` lands at element position e of the selected slice row. Element e occupies bytes e*EB to e*EB+EB-1, where EB = 2^`cmd_esz` bytes.
- R3: Vertical write (`cmd_vert`=1): element r of `cmd_src` lands at element position `slice` in row r of the tile, for every row r of the tile.
- R4: The slice number is (`cmd_index` + `cmd_off`) modulo D, where D = 16/EB is the tile side in elements. The sum is taken over the full 32-bit index.
- R5: An element is active when the `cmd_pred` bit of its lowest byte (bit e*EB) is set. Inactive elements keep their old storage value, and the other predicate bits have no effect.
- R6: Tiles are interleaved by row. Row r of tile t is physical row r*EB + t. Tiles other than the one addressed are never modified.
- R7: A command whose tile number is not below EB writes nothing, and drives `cmd_err` high for the one cycle after the accepting edge.
- R8: A command whose offset is not below 16/EB, or whose size code exceeds 4, writes nothing and raises `cmd_err` in the same way. `cmd_err` is high only after such a command.
- R9: When `cmd_valid` is low, no storage byte changes.
- R10: `rd_data` shows physical row `rd_row` as it was before the clock edge on which `rd_row` was sampled. It appears one cycle later, so a write on that same edge is not yet visible.

Size codes for `cmd_esz`: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit, 4 = 128-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command applied on this edge |
| cmd_esz | input | 3 | Element size code |
| cmd_tile | input | 4 | Tile number |
| cmd_vert | input | 1 | 0 = row slice, 1 = column slice |
| cmd_index | input | 32 | Slice index value |
| cmd_off | input | 4 | Immediate slice offset |
| cmd_src | input | 128 | Source vector |
| cmd_pred | input | 16 | Predicate, one bit per byte |
| rd_row | input | 4 | Physical row to read |
| rd_data | output | 128 | Registered read data |
| cmd_err | output | 1 | Rejected-command pulse |

## Verification
The bound checker watches the following properties on every cycle:
- No byte enable fires while the command is idle or rejected.
- A row write touches at most one physical row.
- A column write enables no more than one vector's worth of bytes.
- The error pulse follows exactly the rejected commands.

Whether the right bytes receive the right data cannot be seen from enables alone. That covers the modulo wrap of the index, the tile interleave, the predicate keyed on each element's lowest byte, and the read-before-write order of the read port. These are shown by the bench: it reads back every row after each directed and random command and compares against its own model.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef enum logic [2:0] {
    ESZ_8   = 3'd0,
    ESZ_16  = 3'd1,
    ESZ_32  = 3'd2,
    ESZ_64  = 3'd3,
    ESZ_128 = 3'd4
  } esz_e;

  // elements per 128-bit segment bound the immediate offset
  localparam int SEG_BYTES = 16;
endpackage

// File: rtl/mtx_slice_decode.sv
module mtx_slice_decode
  import mtx_pkg::*;
#(
  parameter int VLB = 16,
  parameter int TW  = 4,
  parameter int OW  = 4,
  parameter int SW  = 4
) (
  input  logic          valid,
  input  logic [2:0]    esz,
  input  logic [TW-1:0] tile,
  input  logic [31:0]   index,
  input  logic [OW-1:0] off,
  output logic          go,
  output logic          bad,
  output logic [2:0]    lg,
  output logic [SW-1:0] slice
);
  localparam int ESZ_MAX = $clog2(VLB);

  logic        esz_ok, tile_ok, off_ok;
  logic [31:0] sum, dim;

  always_comb begin
    esz_ok  = (32'(esz) <= ESZ_MAX);
    lg      = esz_ok ? esz : 3'd0;
    dim     = 32'(VLB) >> lg;
    sum     = index + 32'(off);
    slice   = SW'(sum & (dim - 32'd1));
    tile_ok = 32'(tile) < (32'd1 << lg);
    off_ok  = 32'(off) < (32'(SEG_BYTES) >> lg);
    go      = valid && esz_ok && tile_ok && off_ok;
    bad     = valid && !(esz_ok && tile_ok && off_ok);
  end
endmodule

// File: rtl/mtx_lane_mapper.sv
module mtx_lane_mapper #(
  parameter int VL_BITS = 128,
  parameter int VLB     = VL_BITS / 8,
  parameter int TW      = 4,
  parameter int SW      = 4
) (
  input  logic                          go,
  input  logic                          vert,
  input  logic [2:0]                    lg,
  input  logic [TW-1:0]                 tile,
  input  logic [SW-1:0]                 slice,
  input  logic [VL_BITS-1:0]            src,
  input  logic [VLB-1:0]                pred,
  output logic [VLB*VLB-1:0]            be,
  output logic [VLB-1:0][VL_BITS-1:0]   wrow
);
  for (genvar p = 0; p < VLB; p++) begin : g_row
    for (genvar b = 0; b < VLB; b++) begin : g_byte
      logic       hit;
      logic [7:0] dbyte;

      always_comb begin
        int emask, row_r, sb;
        emask = (1 << lg) - 1;
        row_r = p >> lg;
        if (!vert) begin
          hit = go && ((p & emask) == int'(tile)) && (row_r == int'(slice))
                && pred[b & ~emask];
          sb  = b;
        end else begin
          hit = go && ((p & emask) == int'(tile)) && ((b >> lg) == int'(slice))
                && pred[(row_r << lg) & (VLB - 1)];
          sb  = ((row_r << lg) | (b & emask)) & (VLB - 1);
        end
        dbyte = src[sb*8 +: 8];
      end

      assign be[p*VLB + b]     = hit;
      assign wrow[p][b*8 +: 8] = dbyte;
    end
  end
endmodule

// File: rtl/mtx_row_store.sv
module mtx_row_store #(
  parameter int VL_BITS = 128,
  parameter int VLB     = VL_BITS / 8,
  parameter int RW      = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [VLB*VLB-1:0]          be,
  input  logic [VLB-1:0][VL_BITS-1:0] wrow,
  input  logic [RW-1:0]               rd_row,
  output logic [VL_BITS-1:0]          rd_data
);
  logic [VL_BITS-1:0] mem [VLB];

  always_ff @(posedge clk) begin
    for (int p = 0; p < VLB; p++) begin
      for (int b = 0; b < VLB; b++) begin
        if (rst)
          mem[p][b*8 +: 8] <= 8'd0;
        else if (be[p*VLB + b])
          mem[p][b*8 +: 8] <= wrow[p][b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mem[rd_row];
  end
endmodule

// File: rtl/matrix_slice_writer.sv
module matrix_slice_writer
  import mtx_pkg::*;
#(
  parameter int VL_BITS = 128,
  localparam int VLB    = VL_BITS / 8,
  localparam int TW     = $clog2(VLB),
  localparam int OW     = $clog2(SEG_BYTES),
  localparam int SW     = $clog2(VLB),
  localparam int RW     = $clog2(VLB)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_esz,
  input  logic [TW-1:0]      cmd_tile,
  input  logic               cmd_vert,
  input  logic [31:0]        cmd_index,
  input  logic [OW-1:0]      cmd_off,
  input  logic [VL_BITS-1:0] cmd_src,
  input  logic [VLB-1:0]     cmd_pred,
  input  logic [RW-1:0]      rd_row,
  output logic [VL_BITS-1:0] rd_data,
  output logic               cmd_err
);
  logic                        go, bad;
  logic [2:0]                  lg;
  logic [SW-1:0]               slice;
  logic [VLB*VLB-1:0]          wr_be;
  logic [VLB-1:0][VL_BITS-1:0] wr_row;

  mtx_slice_decode #(.VLB(VLB), .TW(TW), .OW(OW), .SW(SW)) i_dec (
    .valid (cmd_valid),
    .esz   (cmd_esz),
    .tile  (cmd_tile),
    .index (cmd_index),
    .off   (cmd_off),
    .go    (go),
    .bad   (bad),
    .lg    (lg),
    .slice (slice)
  );

  mtx_lane_mapper #(.VL_BITS(VL_BITS), .VLB(VLB), .TW(TW), .SW(SW)) i_map (
    .go    (go),
    .vert  (cmd_vert),
    .lg    (lg),
    .tile  (cmd_tile),
    .slice (slice),
    .src   (cmd_src),
    .pred  (cmd_pred),
    .be    (wr_be),
    .wrow  (wr_row)
  );

  mtx_row_store #(.VL_BITS(VL_BITS), .VLB(VLB), .RW(RW)) i_store (
    .clk     (clk),
    .rst     (rst),
    .be      (wr_be),
    .wrow    (wr_row),
    .rd_row  (rd_row),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) cmd_err <= 1'b0;
    else     cmd_err <= bad;
  end
endmodule

// File: rtl/mtx_slice_writer_chk.sv
module mtx_slice_writer_chk #(
  parameter int VL_BITS = 128,
  localparam int VLB    = VL_BITS / 8,
  localparam int TW     = $clog2(VLB),
  localparam int OW     = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic [2:0]         cmd_esz,
  input logic [TW-1:0]      cmd_tile,
  input logic               cmd_vert,
  input logic [OW-1:0]      cmd_off,
  input logic               cmd_err,
  input logic [VL_BITS-1:0] rd_data,
  input logic [VLB*VLB-1:0] wr_be
);
  logic           bad_cmd;
  logic [VLB-1:0] row_any;

  always_comb begin
    int tiles, offs;
    tiles = 0;
    offs  = 0;
    case (cmd_esz)
      3'd0: begin tiles = 1;  offs = 16; end
      3'd1: begin tiles = 2;  offs = 8;  end
      3'd2: begin tiles = 4;  offs = 4;  end
      3'd3: begin tiles = 8;  offs = 2;  end
      3'd4: begin tiles = 16; offs = 1;  end
      default: begin tiles = 0; offs = 0; end
    endcase
    bad_cmd = cmd_valid && ((int'(cmd_tile) >= tiles) || (int'(cmd_off) >= offs));
    for (int p = 0; p < VLB; p++) row_any[p] = |wr_be[p*VLB +: VLB];
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !cmd_err));

  assert_err_follows_bad_R7: assert property (@(posedge clk) disable iff (rst)
    bad_cmd |=> cmd_err);

  assert_err_needs_bad_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(bad_cmd));

  assert_bad_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    bad_cmd |-> wr_be == '0);

  assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> wr_be == '0);

  assert_horiz_one_row_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_vert) |-> $countones(row_any) <= 1);

  assert_vert_bytes_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_vert) |-> $countones(wr_be) <= VLB);
endmodule

bind matrix_slice_writer mtx_slice_writer_chk #(.VL_BITS(VL_BITS)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_esz   (cmd_esz),
  .cmd_tile  (cmd_tile),
  .cmd_vert  (cmd_vert),
  .cmd_off   (cmd_off),
  .cmd_err   (cmd_err),
  .rd_data   (rd_data),
  .wr_be     (wr_be)
);

// File: tb/test_matrix_slice_writer.sv
`timescale 1ns/1ps
module test_matrix_slice_writer;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_esz = '0;
  logic [3:0]   cmd_tile = '0;
  logic         cmd_vert = 1'b0;
  logic [31:0]  cmd_index = '0;
  logic [3:0]   cmd_off = '0;
  logic [127:0] cmd_src = '0;
  logic [15:0]  cmd_pred = '0;
  logic [3:0]   rd_row = '0;
  logic [127:0] rd_data;
  logic         cmd_err;

  int tests = 0;
  int fails = 0;
  logic [127:0] mdl [16];

  always #5 clk = ~clk;

  matrix_slice_writer i_matrix_slice_writer (.*);

  function automatic bit is_bad(int esz, int tile, int off);
    int eb;
    if (esz > 4) return 1'b1;
    eb = 1 << esz;
    return (tile >= eb) || (off >= 16 / eb);
  endfunction

  task automatic model_write(int esz, int tile, bit vert, logic [31:0] idx,
                             int off, logic [127:0] src, logic [15:0] pred);
    int eb, dim, sl, p;
    eb  = 1 << esz;
    dim = 16 / eb;
    sl  = int'((longint'(idx) + longint'(off)) % longint'(dim));
    for (int e = 0; e < dim; e++) begin
      if (pred[e*eb]) begin
        for (int k = 0; k < eb; k++) begin
          if (!vert) begin
            p = sl * eb + tile;
            mdl[p][(e*eb+k)*8 +: 8] = src[(e*eb+k)*8 +: 8];
          end else begin
            p = e * eb + tile;
            mdl[p][(sl*eb+k)*8 +: 8] = src[(e*eb+k)*8 +: 8];
          end
        end
      end
    end
  endtask

  task automatic check(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_row(int p, string tag);
    @(negedge clk);
    rd_row = 4'(p);
    @(posedge clk);
    #1;
    check(rd_data === mdl[p], tag, $sformatf("row %0d", p), rd_data, mdl[p]);
  endtask

  task automatic check_all(string tag);
    for (int p = 0; p < 16; p++) check_row(p, tag);
  endtask

  task automatic do_cmd(int esz, int tile, bit vert, logic [31:0] idx, int off,
                        logic [127:0] src, logic [15:0] pred, string tag);
    bit bad;
    bad = is_bad(esz, tile, off);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_esz   = 3'(esz);
    cmd_tile  = 4'(tile);
    cmd_vert  = vert;
    cmd_index = idx;
    cmd_off   = 4'(off);
    cmd_src   = src;
    cmd_pred  = pred;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    check(cmd_err === bad, tag, "cmd_err", 128'(cmd_err), 128'(bad));
    if (!bad) model_write(esz, tile, vert, idx, off, src, pred);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [127:0] old9;
    void'($urandom(32'd4711));
    for (int p = 0; p < 16; p++) mdl[p] = '0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check(cmd_err === 1'b0, "R1", "cmd_err after reset", 128'(cmd_err), 128'd0);
    check_all("R1");

    // R2: 8-bit row slice 5, all bytes active
    do_cmd(0, 0, 1'b0, 32'd5, 0, 128'h0f0e0d0c0b0a09080706050403020100, 16'hffff, "R2");
    check_all("R2");
    // R5: 16-bit tile 1 row slice 3; only element 0 active, odd byte bit ignored
    do_cmd(1, 1, 1'b0, 32'd2, 1, {8{16'hbeef}}, 16'b0000_0010_0000_0001, "R5");
    check_all("R5");
    // R3: 32-bit tile 3 column slice 1
    do_cmd(2, 3, 1'b1, 32'd1, 0, 128'h44444444_33333333_22222222_11111111, 16'hffff, "R3");
    check_all("R3");
    // R4: index wraps, (0xFFFFFFFF + 3) mod 4 = 2
    do_cmd(2, 0, 1'b0, 32'hffff_ffff, 3, {4{32'hcafef00d}}, 16'hffff, "R4");
    check_all("R4");
    // R7: tile 2 does not exist at 16-bit
    do_cmd(1, 2, 1'b0, 32'd0, 0, {8{16'hdead}}, 16'hffff, "R7");
    check_all("R7");
    // R8: offset 2 out of range at 64-bit
    do_cmd(3, 0, 1'b0, 32'd0, 2, {2{64'h1234}}, 16'hffff, "R8");
    check_all("R8");
    // R9: command fields driven with valid low
    @(negedge clk);
    cmd_esz = 3'd0; cmd_tile = 4'd0; cmd_vert = 1'b0; cmd_index = 32'd0;
    cmd_off = 4'd0; cmd_src = {16{8'h99}}; cmd_pred = 16'hffff;
    @(posedge clk);
    check_all("R9");
    // R6: 128-bit tile 15 column, maps to physical row 15
    do_cmd(4, 15, 1'b1, 32'd7, 0, 128'h5a5a_a5a5_0000_ffff_1111_2222_3333_4444, 16'h0001, "R6");
    check_all("R6");
    // R10: read of row 9 on the same edge as its write returns the old value
    old9 = mdl[9];
    @(negedge clk);
    rd_row = 4'd9;
    cmd_valid = 1'b1; cmd_esz = 3'd0; cmd_tile = 4'd0; cmd_vert = 1'b0;
    cmd_index = 32'd9; cmd_off = 4'd0; cmd_src = {16{8'h77}}; cmd_pred = 16'hffff;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    check(rd_data === old9, "R10", "read before write", rd_data, old9);
    model_write(0, 0, 1'b0, 32'd9, 0, {16{8'h77}}, 16'hffff);
    check_row(9, "R10");

    for (int i = 0; i < 250; i++) begin
      int esz, tile, off;
      esz  = int'($urandom % 5);
      tile = ($urandom % 10 == 0) ? int'($urandom % 16) : int'($urandom % (1 << esz));
      off  = ($urandom % 10 == 0) ? int'($urandom % 16) : int'($urandom % (16 >> esz));
      do_cmd(esz, tile, 1'($urandom), $urandom, off,
             {$urandom, $urandom, $urandom, $urandom}, 16'($urandom), "R6");
      check_all("R5");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule